// File: doc/BRIEF.md
# Prioritised Interrupt Vector Controller

This block collects interrupt requests from a small microcontroller subsystem and turns them into a single 16-bit handler-table address for the CPU to fetch. The inputs are the reset causes, three non-maskable-class events (each with its own enable), a comparator, a watchdog interval event, two timer request groups and two 8-bit I/O ports. Each cycle it picks the pending request with the highest priority. It then presents the table address of the winning request with a valid strobe, which is registered one cycle after the inputs.

Table entries lie in the 64-byte window at the top of the 16-bit address space, two bytes per priority level, so the address is `FFC0h + 2*priority`. The reset causes ignore every enable. The non-maskable class obeys only its per-source enables. All other sources also need the global enable. Sources that own a vector by themselves have a latched pending bit, and the CPU's acknowledge clears it. Shared vectors take level flags that software clears. When a reset request is selected and the word stored at the reset entry is still erased (`FFFFh`), the block asks for the deepest low-power state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Any bit of `rst_src_i` selects vector `FFFEh` (priority 31) with `vec_valid_o` high, whatever the global and individual enables are.
- R2: A bit of `nmi_req_i` whose matching `nmi_en_i` bit is 1 selects `FFFCh` (priority 30) even when `gie_i` is 0. A bit whose enable is 0 has no effect.
- R3: Maskable sources need both `gie_i` = 1 and their own enable. Their vectors are: comparator `FFF6h` (27), watchdog interval `FFF4h` (26), timer channel 0 `FFF2h` (25), timer channel 1 or overflow, shared, `FFF0h` (24), port 2, any of 8 bits, `FFE6h` (19), port 1, any of 8 bits, `FFE4h` (18).
- R4: When several requests are pending, the highest priority number wins and `vec_o` = `FFC0h + 2*priority`.
- R5: With no enabled request pending, `vec_valid_o` is 0 and `vec_o` is `0000h`. This is also the state during and right after reset.
- R6: The comparator, watchdog and timer channel 0 requests are latched. A single-cycle pulse stays pending across any number of cycles, and across `gie_i` going low and high again, until it is acknowledged.
- R7: `ack_i` while `vec_valid_o` is high clears the latched bit of a single-source vector. For shared vectors (reset, non-maskable class, timer channel 1/overflow, ports) the request persists for as long as the input flag stays high.
- R8: One cycle after `ack_i` is taken with `vec_valid_o` high, `irq_ack_o` holds the one-hot bit at the acknowledged priority index for one cycle. `ack_i` with `vec_valid_o` low gives `irq_ack_o` = 0.
- R9: `lpm_req_o` is 1 exactly when the selected vector is the reset vector and `rst_vec_i` equals `FFFFh`.
- R10: All outputs are registered. A change at the inputs shows at the outputs after the next rising clock edge.
- R11: A latched source that requests again in the same cycle it is acknowledged stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gie_i | input | 1 | Global enable for maskable sources |
| rst_src_i | input | 5 | Reset causes (power-up, pin, watchdog, key violation, low fetch) |
| nmi_req_i | input | 3 | Non-maskable-class flags (oscillator fault, pin NMI, access violation) |
| nmi_en_i | input | 3 | Individual enables for `nmi_req_i` |
| cmp_req_i | input | 1 | Comparator event, latched |
| cmp_en_i | input | 1 | Comparator enable |
| wdt_req_i | input | 1 | Watchdog interval event, latched |
| wdt_en_i | input | 1 | Watchdog interval enable |
| ta0_req_i | input | 1 | Timer channel 0 event, latched |
| ta0_en_i | input | 1 | Timer channel 0 enable |
| ta1_req_i | input | 2 | Timer channel 1 and overflow flags (level) |
| ta1_en_i | input | 2 | Enables for `ta1_req_i` |
| p2_req_i | input | 8 | Port 2 flags (level) |
| p2_en_i | input | 8 | Port 2 enables |
| p1_req_i | input | 8 | Port 1 flags (level) |
| p1_en_i | input | 8 | Port 1 enables |
| ack_i | input | 1 | CPU takes the presented vector |
| rst_vec_i | input | 16 | Word stored at the reset table entry |
| vec_o | output | 16 | Selected table address |
| vec_valid_o | output | 1 | A request is selected |
| irq_ack_o | output | 32 | One-hot acknowledge by priority index |
| lpm_req_o | output | 1 | Reset entry is erased; enter deepest low-power state |

## Verification
A pending bit that is wrongly kept or lost shows on `vec_o` within one cycle of the acknowledge or request edge. A stuck bit keeps `vec_valid_o` high when it should be low, and a lost pulse makes the expected address never appear. A broken encoder or enable gating gives a wrong address on the first cycle after the inputs settle. The near-exhaustive sweep covers every mix of the eight request classes under both global-enable values, so such an error surfaces as a mismatched address at once. Acknowledge routing is checked on the cycle `irq_ack_o` is due.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_PRIO  = 32;
  localparam int PRIO_W    = $clog2(NUM_PRIO);
  localparam int VEC_W     = 16;
  localparam logic [VEC_W-1:0] VEC_BASE   = 16'hFFC0;
  localparam logic [VEC_W-1:0] BLANK_WORD = 16'hFFFF;

  localparam int PRIO_RST = 31;
  localparam int PRIO_NMI = 30;
  localparam int PRIO_CMP = 27;
  localparam int PRIO_WDT = 26;
  localparam int PRIO_TA0 = 25;
  localparam int PRIO_TA1 = 24;
  localparam int PRIO_P2  = 19;
  localparam int PRIO_P1  = 18;

  // latched single-source vectors: index 0 cmp, 1 wdt, 2 timer ch0
  localparam int NUM_SS = 3;
  localparam logic [PRIO_W-1:0] SS_PRIO [NUM_SS] = '{5'd27, 5'd26, 5'd25};

  function automatic logic [VEC_W-1:0] vec_of(input logic [PRIO_W-1:0] p);
    return VEC_BASE + VEC_W'({p, 1'b0});
  endfunction
endpackage

// File: rtl/irq_pend_flag.sv
module irq_pend_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_d_o
);
  logic flag_q;

  // a new event in the acknowledge cycle wins over the clear
  assign flag_d_o = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d_o;
  end
endmodule

// File: rtl/irq_src_map.sv
module irq_src_map import irq_pkg::*; #(
  parameter int RST_W  = 5,
  parameter int NMI_W  = 3,
  parameter int TA1_W  = 2,
  parameter int PORT_W = 8
) (
  input  logic              gie_i,
  input  logic [RST_W-1:0]  rst_src_i,
  input  logic [NMI_W-1:0]  nmi_req_i,
  input  logic [NMI_W-1:0]  nmi_en_i,
  input  logic [NUM_SS-1:0] ss_flag_i,
  input  logic [NUM_SS-1:0] ss_en_i,
  input  logic [TA1_W-1:0]  ta1_req_i,
  input  logic [TA1_W-1:0]  ta1_en_i,
  input  logic [PORT_W-1:0] p2_req_i,
  input  logic [PORT_W-1:0] p2_en_i,
  input  logic [PORT_W-1:0] p1_req_i,
  input  logic [PORT_W-1:0] p1_en_i,
  output logic [NUM_PRIO-1:0] req_o
);
  logic [NUM_SS-1:0] ss_act;

  for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
    assign ss_act[g] = gie_i & ss_flag_i[g] & ss_en_i[g];
  end

  always_comb begin
    req_o = '0;
    req_o[PRIO_RST] = |rst_src_i;
    req_o[PRIO_NMI] = |(nmi_req_i & nmi_en_i);
    for (int i = 0; i < NUM_SS; i++) begin
      if (ss_act[i]) req_o[SS_PRIO[i]] = 1'b1;
    end
    req_o[PRIO_TA1] = gie_i & |(ta1_req_i & ta1_en_i);
    req_o[PRIO_P2]  = gie_i & |(p2_req_i & p2_en_i);
    req_o[PRIO_P1]  = gie_i & |(p1_req_i & p1_en_i);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N   = 32,
  localparam int W  = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] win_o
);
  always_comb begin
    win_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) win_o = W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl import irq_pkg::*; #(
  parameter int RST_W  = 5,
  parameter int NMI_W  = 3,
  parameter int TA1_W  = 2,
  parameter int PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gie_i,
  input  logic [RST_W-1:0]  rst_src_i,
  input  logic [NMI_W-1:0]  nmi_req_i,
  input  logic [NMI_W-1:0]  nmi_en_i,
  input  logic              cmp_req_i,
  input  logic              cmp_en_i,
  input  logic              wdt_req_i,
  input  logic              wdt_en_i,
  input  logic              ta0_req_i,
  input  logic              ta0_en_i,
  input  logic [TA1_W-1:0]  ta1_req_i,
  input  logic [TA1_W-1:0]  ta1_en_i,
  input  logic [PORT_W-1:0] p2_req_i,
  input  logic [PORT_W-1:0] p2_en_i,
  input  logic [PORT_W-1:0] p1_req_i,
  input  logic [PORT_W-1:0] p1_en_i,
  input  logic              ack_i,
  input  logic [VEC_W-1:0]  rst_vec_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o,
  output logic [NUM_PRIO-1:0] irq_ack_o,
  output logic              lpm_req_o
);
  logic [NUM_SS-1:0]   ss_req, ss_en, ss_flag_d;
  logic [NUM_PRIO-1:0] req;
  logic                any;
  logic [PRIO_W-1:0]   win, win_q;
  logic                ack_hit;

  assign ss_req  = {ta0_req_i, wdt_req_i, cmp_req_i};
  assign ss_en   = {ta0_en_i,  wdt_en_i,  cmp_en_i};
  assign ack_hit = ack_i & vec_valid_o;

  for (genvar g = 0; g < NUM_SS; g++) begin : g_flag
    irq_pend_flag i_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (ss_req[g]),
      .clr_i    (ack_hit && (win_q == SS_PRIO[g])),
      .flag_d_o (ss_flag_d[g])
    );
  end

  irq_src_map #(
    .RST_W(RST_W), .NMI_W(NMI_W), .TA1_W(TA1_W), .PORT_W(PORT_W)
  ) i_map (
    .gie_i     (gie_i),
    .rst_src_i (rst_src_i),
    .nmi_req_i (nmi_req_i),
    .nmi_en_i  (nmi_en_i),
    .ss_flag_i (ss_flag_d),
    .ss_en_i   (ss_en),
    .ta1_req_i (ta1_req_i),
    .ta1_en_i  (ta1_en_i),
    .p2_req_i  (p2_req_i),
    .p2_en_i   (p2_en_i),
    .p1_req_i  (p1_req_i),
    .p1_en_i   (p1_en_i),
    .req_o     (req)
  );

  irq_prio_enc #(.N(NUM_PRIO)) i_enc (
    .req_i (req),
    .any_o (any),
    .win_o (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q       <= '0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
      irq_ack_o   <= '0;
      lpm_req_o   <= 1'b0;
    end else begin
      win_q       <= win;
      vec_valid_o <= any;
      vec_o       <= any ? vec_of(win) : '0;
      irq_ack_o   <= ack_hit ? (NUM_PRIO'(1) << win_q) : '0;
      lpm_req_o   <= any && (win == PRIO_W'(PRIO_RST)) && (rst_vec_i == BLANK_WORD);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk import irq_pkg::*; #(
  parameter int RST_W = 5,
  parameter int NMI_W = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [RST_W-1:0]    rst_src_i,
  input logic [NMI_W-1:0]    nmi_req_i,
  input logic [NMI_W-1:0]    nmi_en_i,
  input logic                ack_i,
  input logic [VEC_W-1:0]    vec_o,
  input logic                vec_valid_o,
  input logic [NUM_PRIO-1:0] irq_ack_o,
  input logic                lpm_req_o
);
  a_r1_reset_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(|rst_src_i)) |-> (vec_valid_o && vec_o == 16'hFFFE));

  a_r2_nmi_no_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(|rst_src_i) && $past(|(nmi_req_i & nmi_en_i)))
      |-> (vec_valid_o && vec_o == 16'hFFFC));

  a_r4_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_o[15:6] == 10'h3FF && !vec_o[0]));

  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> (vec_o == '0 && !lpm_req_o));

  a_r8_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_ack_o));

  a_r8_ack_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o != '0) |-> ($past(ack_i) && $past(vec_valid_o)));

  a_r9_blank_on_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpm_req_o |-> (vec_o == 16'hFFFE));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.RST_W(RST_W), .NMI_W(NMI_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rst_src_i(rst_src_i),
  .nmi_req_i(nmi_req_i), .nmi_en_i(nmi_en_i), .ack_i(ack_i),
  .vec_o(vec_o), .vec_valid_o(vec_valid_o), .irq_ack_o(irq_ack_o),
  .lpm_req_o(lpm_req_o)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0, gie_i = 1'b0;
  logic [4:0] rst_src_i = '0;
  logic [2:0] nmi_req_i = '0, nmi_en_i = '0;
  logic cmp_req_i = 0, cmp_en_i = 0, wdt_req_i = 0, wdt_en_i = 0;
  logic ta0_req_i = 0, ta0_en_i = 0;
  logic [1:0] ta1_req_i = '0, ta1_en_i = '0;
  logic [7:0] p2_req_i = '0, p2_en_i = '0, p1_req_i = '0, p1_en_i = '0;
  logic ack_i = 0;
  logic [15:0] rst_vec_i = 16'h8000;
  logic [15:0] vec_o;
  logic vec_valid_o, lpm_req_o;
  logic [31:0] irq_ack_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_vector_ctrl i_irq_vector_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    gie_i = 0; rst_src_i = '0; nmi_req_i = '0; nmi_en_i = '0;
    cmp_req_i = 0; cmp_en_i = 0; wdt_req_i = 0; wdt_en_i = 0;
    ta0_req_i = 0; ta0_en_i = 0; ta1_req_i = '0; ta1_en_i = '0;
    p2_req_i = '0; p2_en_i = '0; p1_req_i = '0; p1_en_i = '0;
    ack_i = 0; rst_vec_i = 16'h8000;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0; clear_inputs();
    @(negedge clk_i); rst_ni = 1;
  endtask

  function automatic logic [16:0] vexp(input int prio);
    if (prio < 0) return 17'h0;
    return {1'b1, 16'hFFC0 + 16'(2 * prio)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R5 reset state
    @(negedge clk_i);
    check("R5 valid/vec in reset", {15'd0, vec_valid_o, vec_o}, 32'h0);
    check("R8 ack in reset", irq_ack_o, 32'h0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    check("R5 idle after reset", {15'd0, lpm_req_o, vec_valid_o, vec_o}, 32'h0);

    // R4 sweep over all class mixes and both global-enable values
    for (int g = 0; g < 2; g++) begin
      for (int c = 0; c < 256; c++) begin
        int ex;
        @(negedge clk_i); rst_ni = 0; clear_inputs();
        gie_i = g[0];
        rst_src_i = c[0] ? 5'(1 << (c % 5)) : '0;
        nmi_req_i = c[1] ? 3'(1 << (c % 3)) : '0; nmi_en_i = '1;
        cmp_req_i = c[2]; cmp_en_i = 1;
        wdt_req_i = c[3]; wdt_en_i = 1;
        ta0_req_i = c[4]; ta0_en_i = 1;
        ta1_req_i = c[5] ? 2'(1 << (c % 2)) : '0; ta1_en_i = '1;
        p2_req_i = c[6] ? 8'(1 << (c % 8)) : '0; p2_en_i = '1;
        p1_req_i = c[7] ? 8'(1 << ((c + 3) % 8)) : '0; p1_en_i = '1;
        rst_vec_i = (c % 3 == 0) ? 16'hFFFF : 16'h4400;
        ex = -1;
        if (g == 1) begin
          if (c[7]) ex = 18;
          if (c[6]) ex = 19;
          if (c[5]) ex = 24;
          if (c[4]) ex = 25;
          if (c[3]) ex = 26;
          if (c[2]) ex = 27;
        end
        if (c[1]) ex = 30;
        if (c[0]) ex = 31;
        @(negedge clk_i); rst_ni = 1;
        @(negedge clk_i);
        check($sformatf("R4 sweep g=%0d c=%0d", g, c), {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(ex)});
        check($sformatf("R9 sweep g=%0d c=%0d", g, c), {31'd0, lpm_req_o},
              {31'd0, c[0] && (c % 3 == 0)});
      end
    end

    // R1 reset cause ignores enables
    do_reset();
    rst_src_i = 5'b10000;
    @(negedge clk_i);
    check("R1 reset vector without enables", {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(31)});
    // R9 blank word
    rst_vec_i = 16'hFFFF;
    @(negedge clk_i);
    check("R9 blank reset entry", {31'd0, lpm_req_o}, 32'd1);
    rst_vec_i = 16'h1234;
    @(negedge clk_i);
    check("R9 programmed reset entry", {31'd0, lpm_req_o}, 32'd0);
    rst_src_i = '0; rst_vec_i = 16'hFFFF; nmi_req_i = 3'b001; nmi_en_i = 3'b001;
    @(negedge clk_i);
    check("R9 blank but reset not selected", {31'd0, lpm_req_o}, 32'd0);
    check("R2 nmi with gie low", {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(30)});
    nmi_en_i = 3'b110;
    @(negedge clk_i);
    check("R2 disabled nmi source", {15'd0, vec_valid_o, vec_o}, 32'h0);

    // R3 enables gate maskable sources
    do_reset();
    gie_i = 1; p1_req_i = 8'h01; p1_en_i = 8'h02; ta1_req_i = 2'b10; ta1_en_i = 2'b01;
    @(negedge clk_i);
    check("R3 disabled shared bits", {15'd0, vec_valid_o, vec_o}, 32'h0);
    p1_en_i = 8'h01;
    @(negedge clk_i);
    check("R3 port1 enabled", {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(18)});
    gie_i = 0;
    @(negedge clk_i);
    check("R3 gie low hides port1", {15'd0, vec_valid_o, vec_o}, 32'h0);

    // R6 latch a one-cycle pulse, survives gie toggle
    do_reset();
    ta0_en_i = 1; ta0_req_i = 1;
    @(negedge clk_i); ta0_req_i = 0;
    @(negedge clk_i);
    check("R6 latched while gie low", {15'd0, vec_valid_o, vec_o}, 32'h0);
    gie_i = 1;
    @(negedge clk_i);
    check("R6 pulse held, R10 one edge", {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(25)});
    repeat (5) @(negedge clk_i);
    check("R6 still pending", {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(25)});

    // R7/R8 ack clears single-source flag
    ack_i = 1;
    @(negedge clk_i); ack_i = 0;
    check("R8 ack one-hot bit 25", irq_ack_o, 32'h1 << 25);
    check("R7 single-source cleared", {15'd0, vec_valid_o, vec_o}, 32'h0);
    @(negedge clk_i);
    check("R8 ack one cycle only", irq_ack_o, 32'h0);
    ack_i = 1;
    @(negedge clk_i); ack_i = 0;
    check("R8 ack with valid low", irq_ack_o, 32'h0);

    // R11 new event in ack cycle
    cmp_en_i = 1; cmp_req_i = 1;
    @(negedge clk_i); cmp_req_i = 0;
    @(negedge clk_i);
    check("R11 comparator pending", {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(27)});
    ack_i = 1; cmp_req_i = 1;
    @(negedge clk_i); ack_i = 0; cmp_req_i = 0;
    check("R11 ack bit 27", irq_ack_o, 32'h1 << 27);
    check("R11 set beats clear", {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(27)});
    ack_i = 1;
    @(negedge clk_i); ack_i = 0;
    check("R7 comparator cleared", {15'd0, vec_valid_o, vec_o}, 32'h0);

    // R7 shared vector persists
    wdt_en_i = 1; wdt_req_i = 1; p2_en_i = 8'h80; p2_req_i = 8'h80;
    @(negedge clk_i); wdt_req_i = 0;
    check("R4 watchdog over port2", {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(26)});
    ack_i = 1;
    @(negedge clk_i); ack_i = 0;
    check("R7 watchdog cleared, port2 next", {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(19)});
    check("R8 ack bit 26", irq_ack_o, 32'h1 << 26);
    ack_i = 1;
    @(negedge clk_i); ack_i = 0;
    check("R8 ack bit 19", irq_ack_o, 32'h1 << 19);
    check("R7 shared port2 persists", {15'd0, vec_valid_o, vec_o}, {15'd0, vexp(19)});
    p2_req_i = '0;
    @(negedge clk_i);
    check("R10 port2 drop after one edge", {15'd0, vec_valid_o, vec_o}, 32'h0);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule